// File: doc/BRIEF.md
# Lane Drive Level Adjust Merger

This block takes the per-lane drive adjustment requests that a DisplayPort sink reports during link training. It reduces them to one drive setting that all lanes share. For each lane the sink asks for a voltage-swing level and a pre-emphasis level. The block takes the largest of each over the lanes in use, limits the swing to what the transmitter can drive, and then limits the pre-emphasis to the ceiling allowed at that swing. A flag is raised whenever a value meets its limit.

The result is four identical training-set bytes. The link-training sequencer writes them to the sink and to the transmitter's drive circuits. A one-cycle start pulse captures the inputs. The bytes are updated at that clock edge, and a one-cycle done strobe marks them. The bytes then hold their value until the next start.

Top module: `lane_drive_merge`

## Requirements
- R1: Lanes whose index is not below the effective active lane count have no effect on the result, whatever they request.
- R2: The chosen swing is the largest swing request among the active lanes.
- R3: The chosen pre-emphasis is the largest pre-emphasis request among the active lanes.
- R4: If the chosen swing is greater than or equal to `swing_cap`, the swing field becomes `swing_cap` and the swing-limit flag is 1. Otherwise the swing field is the chosen swing and the flag is 0.
- R5: The pre-emphasis ceiling is the 2-bit entry of `emph_ceil_tbl` at bits [2*s+1:2*s]. Here s is the final swing field after clamping, not the requested swing.
- R6: If the chosen pre-emphasis is greater than or equal to that ceiling, the pre-emphasis field becomes the ceiling and its flag is 1. Otherwise the field is the chosen pre-emphasis and the flag is 0.
- R7: All four output bytes carry the same value, whatever the active lane count.
- R8: Byte layout: swing in bits [1:0], swing-limit flag in bit 2, pre-emphasis in bits [4:3], pre-emphasis-limit flag in bit 5, and bits [7:6] are 0. Byte n of `train_set` is `train_set[8n+7:8n]`.
- R9: `done` is 1 exactly in the cycle after a cycle in which `start` was 1. `train_set` takes its new value at that same edge and holds it while `start` is 0.
- R10: An active lane count of 1, 2 or 4 is used as given. Any other value (0, 3, 5, 6, 7) is treated as 4.
- R11: After reset, `train_set` is all zeros and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture the inputs and compute a new setting |
| lane_cnt | input | 3 | Active lane count |
| swing_req | input | 8 | Swing request per lane, lane n in bits [2n+1:2n] |
| emph_req | input | 8 | Pre-emphasis request per lane, lane n in bits [2n+1:2n] |
| swing_cap | input | 2 | Highest swing level the transmitter supports |
| emph_ceil_tbl | input | 8 | Pre-emphasis ceiling for each swing level s, in bits [2s+1:2s] |
| train_set | output | 32 | Four identical training-set bytes |
| done | output | 1 | Result valid strobe, one cycle |

## Verification
The assertions assume that `start` and the other inputs are settled well before each rising edge. They also assume that `start` is held low during reset, because the done check compares with the start value from one cycle earlier.

The bench drives every input at the falling edge and keeps `start` low throughout reset. Random lane counts include the illegal values. Random requests on inactive lanes are often set to level 3 to test that those lanes are ignored. Directed cases force both clamps at `swing_cap` values 0 and 3, and also cover ceiling tables in which the entry for the requested swing differs from the entry for the clamped swing.

// File: rtl/lane_drive_pkg.sv
package lane_drive_pkg;

   // Layout of one training-set byte, for a field width of w bits
   function automatic int swing_lsb(input int w);
      return 0;
   endfunction

   function automatic int swing_flag_bit(input int w);
      return w;
   endfunction

   function automatic int emph_lsb(input int w);
      return w + 1;
   endfunction

   function automatic int emph_flag_bit(input int w);
      return 2 * w + 1;
   endfunction

   // Pick field idx of width w from a packed table
   function automatic logic [7:0] pick_field(input logic [31:0] tbl, input int idx, input int w);
      logic [31:0] sh;
      sh = tbl >> (idx * w);
      return sh[7:0] & 8'((1 << w) - 1);
   endfunction

endpackage

// File: rtl/ldm_lane_mask.sv
module ldm_lane_mask #(
   parameter int LANES = 4,
   parameter int CNT_W = $clog2(LANES + 1)
) (
   input  logic [CNT_W-1:0] lane_cnt,
   output logic [LANES-1:0] active
);
   logic legal;

   always_comb begin
      legal = (lane_cnt != '0) &&
              ((lane_cnt & (lane_cnt - CNT_W'(1))) == '0) &&
              (lane_cnt <= CNT_W'(LANES));
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign active[i] = legal ? (CNT_W'(i) < lane_cnt) : 1'b1;
   end

   // R10: lane 0 always takes part
   always_comb begin
      assert_lane0_active_R10: assert (active[0] === 1'b1 || $isunknown(lane_cnt));
   end
endmodule

// File: rtl/ldm_max_reduce.sv
module ldm_max_reduce #(
   parameter int LANES = 4,
   parameter int W     = 2
) (
   input  logic [LANES*W-1:0] req,
   input  logic [LANES-1:0]   active,
   output logic [W-1:0]       max_o
);
   logic [W-1:0] chain [LANES+1];

   assign chain[0] = '0;

   for (genvar i = 0; i < LANES; i++) begin : g_step
      logic [W-1:0] lane_v;
      assign lane_v = active[i] ? req[i*W +: W] : '0;
      assign chain[i+1] = (lane_v > chain[i]) ? lane_v : chain[i];
   end

   assign max_o = chain[LANES];
endmodule

// File: rtl/ldm_clamp.sv
module ldm_clamp #(
   parameter int W     = 2,
   parameter int NLVL  = 1 << W
) (
   input  logic [W-1:0]      swing_in,
   input  logic [W-1:0]      emph_in,
   input  logic [W-1:0]      swing_cap,
   input  logic [NLVL*W-1:0] ceil_tbl,
   output logic [W-1:0]      swing_o,
   output logic              swing_hit,
   output logic [W-1:0]      emph_o,
   output logic              emph_hit
);
   logic [W-1:0] ceil_sel;

   always_comb begin
      swing_hit = (swing_in >= swing_cap);
      swing_o   = swing_hit ? swing_cap : swing_in;
      // R5: ceiling indexed by the clamped swing
      ceil_sel  = ceil_tbl[swing_o*W +: W];
      emph_hit  = (emph_in >= ceil_sel);
      emph_o    = emph_hit ? ceil_sel : emph_in;
   end
endmodule

// File: rtl/lane_drive_merge.sv
module lane_drive_merge #(
   parameter int LANES = 4,
   parameter int W     = 2,
   localparam int NLVL  = 1 << W,
   localparam int CNT_W = $clog2(LANES + 1),
   localparam int BYTE  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [CNT_W-1:0]      lane_cnt,
   input  logic [LANES*W-1:0]    swing_req,
   input  logic [LANES*W-1:0]    emph_req,
   input  logic [W-1:0]          swing_cap,
   input  logic [NLVL*W-1:0]     emph_ceil_tbl,
   output logic [LANES*BYTE-1:0] train_set,
   output logic                  done
);
   import lane_drive_pkg::*;

   localparam int PAD = BYTE - 2 * W - 2;

   if (PAD < 0) begin : g_bad_width
      $error("lane_drive_merge: W too large for an 8-bit training byte");
   end
   if (LANES < 1) begin : g_bad_lanes
      $error("lane_drive_merge: LANES must be at least 1");
   end

   logic [LANES-1:0] active;
   logic [W-1:0]     swing_max, emph_max;
   logic [W-1:0]     swing_f, emph_f;
   logic             swing_hit, emph_hit;
   logic [BYTE-1:0]  byte_d;
   logic [LANES*BYTE-1:0] train_q;
   logic             done_q;

   ldm_lane_mask #(.LANES(LANES), .CNT_W(CNT_W)) u_mask (
      .lane_cnt (lane_cnt),
      .active   (active)
   );

   ldm_max_reduce #(.LANES(LANES), .W(W)) u_swing_max (
      .req    (swing_req),
      .active (active),
      .max_o  (swing_max)
   );

   ldm_max_reduce #(.LANES(LANES), .W(W)) u_emph_max (
      .req    (emph_req),
      .active (active),
      .max_o  (emph_max)
   );

   ldm_clamp #(.W(W), .NLVL(NLVL)) u_clamp (
      .swing_in  (swing_max),
      .emph_in   (emph_max),
      .swing_cap (swing_cap),
      .ceil_tbl  (emph_ceil_tbl),
      .swing_o   (swing_f),
      .swing_hit (swing_hit),
      .emph_o    (emph_f),
      .emph_hit  (emph_hit)
   );

   if (PAD > 0) begin : g_pad
      assign byte_d = {{PAD{1'b0}}, emph_hit, emph_f, swing_hit, swing_f};
   end else begin : g_nopad
      assign byte_d = {emph_hit, emph_f, swing_hit, swing_f};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         train_q <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= start;
         if (start) begin
            train_q <= {LANES{byte_d}};
         end
      end
   end

   assign train_set = train_q;
   assign done      = done_q;

   // R9: done follows start by one cycle
   assert_done_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done == $past(start));

   // R9: result holds without start
   assert_hold_without_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(start) |-> $stable(train_set));

   // R4: swing never exceeds the cap seen at capture
   assert_swing_capped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (train_set[W-1:0] <= $past(swing_cap)));

   // R4: flag means swing equals cap
   assert_swing_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && train_set[swing_flag_bit(W)]) |-> (train_set[W-1:0] == $past(swing_cap)));

   // R6: pre-emphasis never above ceiling at the final swing
   assert_emph_capped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (8'(train_set[emph_lsb(W) +: W]) <=
                pick_field(32'($past(emph_ceil_tbl)), int'(train_set[W-1:0]), W)));

   // R8: unused bits are zero
   assert_pad_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (train_set[BYTE-1:2*W+2] == '0));

   // R7: every byte equals byte 0
   for (genvar l = 1; l < LANES; l++) begin : g_same
      assert_bytes_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
         train_set[l*BYTE +: BYTE] == train_set[BYTE-1:0]);
   end
endmodule

// File: tb/sim_lane_drive_merge.sv
`timescale 1ns/1ps
module sim_lane_drive_merge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  lane_cnt = 3'd4;
   logic [7:0]  swing_req = '0;
   logic [7:0]  emph_req = '0;
   logic [1:0]  swing_cap = 2'd3;
   logic [7:0]  emph_ceil_tbl = 8'hFF;
   logic [31:0] train_set;
   logic        done;

   int checks = 0;
   int bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   lane_drive_merge u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .lane_cnt(lane_cnt),
      .swing_req(swing_req), .emph_req(emph_req), .swing_cap(swing_cap),
      .emph_ceil_tbl(emph_ceil_tbl), .train_set(train_set), .done(done)
   );

   function automatic logic [7:0] model(input logic [2:0] cnt, input logic [7:0] sr,
                                        input logic [7:0] er, input logic [1:0] cap,
                                        input logic [7:0] tbl);
      int n;
      logic [1:0] s, e, lim;
      logic sf, ef;
      n = (cnt == 3'd1 || cnt == 3'd2 || cnt == 3'd4) ? int'(cnt) : 4;
      s = 0; e = 0;
      for (int i = 0; i < n; i++) begin
         if (sr[2*i +: 2] > s) s = sr[2*i +: 2];
         if (er[2*i +: 2] > e) e = er[2*i +: 2];
      end
      sf = (s >= cap);
      if (sf) s = cap;
      lim = tbl[2*s +: 2];
      ef = (e >= lim);
      if (ef) e = lim;
      return {2'b00, ef, e, sf, s};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run(input string req, input logic [2:0] cnt, input logic [7:0] sr,
                      input logic [7:0] er, input logic [1:0] cap, input logic [7:0] tbl);
      logic [7:0]  b;
      logic [31:0] prev;
      b = model(cnt, sr, er, cap, tbl);
      @(negedge clk);
      lane_cnt = cnt; swing_req = sr; emph_req = er; swing_cap = cap; emph_ceil_tbl = tbl;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk({req, " R9 done"}, 32'(done), 32'd1);
      chk({req, " R7 R8 bytes"}, train_set, {4{b}});
      prev = train_set;
      // scramble inputs without start: output must hold
      lane_cnt = ~cnt; swing_req = ~sr; emph_req = ~er; swing_cap = ~cap;
      @(negedge clk);
      chk({req, " R9 done low"}, 32'(done), 32'd0);
      chk({req, " R9 hold"}, train_set, prev);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11 reset bytes", train_set, 32'd0);
      chk("R11 reset done", 32'(done), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 idle after reset", train_set, 32'd0);

      // R1: one lane active, others request max
      run("R1 one lane", 3'd1, 8'b11111100, 8'b11111101, 2'd3, 8'hFF);
      chk("R1 expect byte", train_set[7:0], 8'b00001000);
      // R1 two lanes
      run("R1 two lanes", 3'd2, 8'b11110110, 8'b11110001, 2'd3, 8'hFF);
      // R2/R3: max over four lanes
      run("R2 R3 four lanes", 3'd4, 8'b00100100, 8'b01000000, 2'd3, 8'hFF);
      // R4: swing clamp, cap 0
      run("R4 cap zero", 3'd4, 8'b00000000, 8'b00000000, 2'd0, 8'hFF);
      chk("R4 cap zero flag", train_set[7:0], 8'b00000100);
      // R4: swing clamp with cap 3
      run("R4 cap three", 3'd4, 8'b11000000, 8'b00000000, 2'd3, 8'hFF);
      // R5: ceiling from clamped swing (requested 3, cap 1, tbl[1]=0, tbl[3]=3)
      run("R5 clamped index", 3'd4, 8'b00000011, 8'b00000010, 2'd1, 8'b11_10_00_11);
      chk("R5 expect byte", train_set[7:0], 8'b00100101);
      // R6: pre-emphasis equals ceiling
      run("R6 at ceiling", 3'd4, 8'b00000001, 8'b00000010, 2'd3, 8'b00_00_10_00);
      chk("R6 expect byte", train_set[7:0], 8'b00110001);
      // R6: below ceiling
      run("R6 below ceiling", 3'd4, 8'b00000001, 8'b00000001, 2'd3, 8'b00_00_11_00);
      // R10: illegal counts treated as four
      run("R10 count 0", 3'd0, 8'b10000000, 8'b01000000, 2'd3, 8'hFF);
      chk("R10 count 0 byte", train_set[7:0], 8'b00001010);
      run("R10 count 3", 3'd3, 8'b11000000, 8'b00000000, 2'd3, 8'hFF);
      run("R10 count 7", 3'd7, 8'b01000000, 8'b10000000, 2'd3, 8'hFF);

      // random mix
      for (int k = 0; k < 300; k++) begin
         logic [2:0] c;
         logic [7:0] sr, er;
         c  = 3'($urandom_range(0, 7));
         sr = 8'($urandom);
         er = 8'($urandom);
         if ($urandom_range(0, 1) == 1) begin
            sr[7:4] = 4'hF;
            er[7:4] = 4'hF;
         end
         run("R1 R2 R3 R6 random", c, sr, er, 2'($urandom), 8'($urandom));
      end
      finished = 1;
   end

   initial begin
      fork
         wait (finished);
         begin
            repeat (50000) @(posedge clk);
            checks++;
            bad++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
         end
      join_any
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule